// File: doc/BRIEF.md
# SPI Master Byte Engine

This block is a single-channel SPI master. It takes bytes from a host over a valid/ready transmit port, shifts each one out on MOSI and, on the same serial clock edges, assembles a byte from MISO that it then presents on a receive port with a one-cycle strobe. A set of plain configuration inputs chooses the bit order, the clock phase and idle polarity, the active level of the single chip-select line, whether chip-select is released between consecutive bytes, and a software override that drives chip-select directly. The serial clock half-period comes from an 8-bit divider of the system clock.

On the transmit port, a byte is taken in any cycle where both `tx_valid` and `tx_ready` are high. `tx_ready` is high while the engine is idle. During a transfer, `tx_ready` is high only in the single cycle that carries the last serial clock edge of the current byte. A host that keeps `tx_valid` high therefore chains bytes with no idle cycles between them. A host that drops `tx_valid` lets the engine return to idle. The receive side has no back-pressure: `rx_data` holds its value until the next completed byte, and `rx_valid` marks the one cycle in which a new byte appears.

The clock-shape settings are latched when a transfer starts. If the live phase or polarity input then differs from the latched value, the transfer in flight is dropped. The bit-order, chip-select and divider settings are also latched at that moment and stay in force until the engine is idle again.

Top module: `spi_byte_master`

## Requirements
- R1: When `cfg_msb_first` is 1, bit 7 of each byte goes out on MOSI first, and the first MISO bit sampled lands in bit 7 of `rx_data`. When it is 0, bit 0 goes first and the first sampled bit lands in bit 0.
- R2: Serial clock edges are numbered 1 to 16 within a byte. With `cfg_cpha` = 0, MISO is sampled on the odd edges and MOSI changes on the even edges. With `cfg_cpha` = 1, MISO is sampled on the even edges and MOSI changes on odd edges 3 to 15. In both modes the first data bit is on MOSI from the moment chip-select asserts.
- R3: With `cfg_cpol` = 0, SCK rests low outside a byte. With `cfg_cpol` = 1, it rests high. After the sixteenth edge, SCK is back at its resting level.
- R4: Each SCK half-period lasts `cfg_half_div` + 1 system clocks. Edge 1 comes one half-period after chip-select asserts.
- R5: With `cfg_cs_active_high` = 0, `cs` is low while a byte is being shifted and high otherwise. With it set to 1, the levels are inverted.
- R6: Suppose a new byte is accepted on the last edge of the current byte. With `cfg_cs_pulse` = 1, chip-select is released for two half-periods, then asserted one half-period before the new edge 1. With `cfg_cs_pulse` = 0, chip-select stays asserted and the new edge 1 follows one half-period after edge 16.
- R7: While `cfg_cs_force_en` is 1, `cs` equals `cfg_cs_force_val` in every cycle, whatever the transfer state. The transfer itself is unaffected.
- R8: If `cfg_cpol` or `cfg_cpha` differs from its value at transfer start while the engine is busy, the engine is idle in the next cycle. The dropped byte produces no `rx_valid`.
- R9: Changes to `cfg_msb_first`, `cfg_cs_pulse`, `cfg_cs_active_high` and `cfg_half_div` while busy do not affect the transfer in flight or any byte chained to it.
- R10: `rx_valid` is high for exactly one cycle, the cycle after the system clock edge that produces SCK edge 16, and `rx_data` carries the byte in that cycle. If no byte was accepted, `busy` falls in the same cycle. `tx_ready` is high when idle and on the cycle of edge 16.
- R11: After reset, `busy` and `rx_valid` are 0, `tx_ready` is 1, and `sck` and `cs` show the idle levels set by the live configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_msb_first | input | 1 | 1 = MSB first, 0 = LSB first |
| cfg_cpha | input | 1 | Clock phase select |
| cfg_cpol | input | 1 | SCK resting level |
| cfg_cs_pulse | input | 1 | Release chip-select between chained bytes |
| cfg_cs_active_high | input | 1 | Chip-select active level |
| cfg_cs_force_en | input | 1 | Drive chip-select from `cfg_cs_force_val` |
| cfg_cs_force_val | input | 1 | Forced chip-select level |
| cfg_half_div | input | 8 | SCK half-period minus one, in system clocks |
| tx_data | input | 8 | Byte to send |
| tx_valid | input | 1 | `tx_data` is offered |
| tx_ready | output | 1 | Engine takes the offered byte this cycle |
| rx_data | output | 8 | Last completed received byte |
| rx_valid | output | 1 | One-cycle strobe for a new `rx_data` |
| busy | output | 1 | A transfer is in progress |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs | output | 1 | Chip-select |

## Verification
MISO is fed from a free-running pseudo-random bit source. This makes any sample taken on the wrong edge show up as a different received byte, which separates the two clock phases. Single bytes are sent under all four phase/polarity pairings and both bit orders, which separates edge placement from bit ordering. Held-valid streams are run with release on and release off, which separates the gap timing from back-to-back chaining. The remaining runs change the frozen settings mid-byte, flip the clock phase mid-byte, and force chip-select; these show that the latched settings are isolated from live changes, that an abort really drops its byte, and that the override is independent of the transfer.

// File: rtl/spi_byte_pkg.sv
package spi_byte_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_GAP   = 2'd2
  } eng_state_t;

  typedef struct packed {
    logic msb_first;
    logic cpha;
    logic cpol;
    logic cs_pulse;
    logic cs_high;
  } frame_cfg_t;

endpackage

// File: rtl/spi_half_timer.sv
module spi_half_timer #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] limit,
  output logic             tick
);

  logic [DIV_W-1:0] cnt_q;

  assign tick = run && (cnt_q == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!run || tick) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/spi_shift_unit.sv
module spi_shift_unit #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              msb_first,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              shift_tx,
  input  logic              sample,
  input  logic              miso,
  output logic              mosi_bit,
  output logic [DATA_W-1:0] rx_capt
);

  logic [DATA_W-1:0] tx_sh;
  logic [DATA_W-1:0] rx_sh;
  logic [DATA_W-1:0] rx_shifted;
  logic [DATA_W-1:0] tx_shifted;

  assign mosi_bit   = msb_first ? tx_sh[DATA_W-1] : tx_sh[0];
  assign tx_shifted = msb_first ? {tx_sh[DATA_W-2:0], 1'b0} : {1'b0, tx_sh[DATA_W-1:1]};
  assign rx_shifted = msb_first ? {rx_sh[DATA_W-2:0], miso} : {miso, rx_sh[DATA_W-1:1]};
  assign rx_capt    = sample ? rx_shifted : rx_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sh <= '0;
      rx_sh <= '0;
    end else begin
      if (load) begin
        tx_sh <= load_data;
      end else if (shift_tx) begin
        tx_sh <= tx_shifted;
      end
      if (sample) begin
        rx_sh <= rx_shifted;
      end
    end
  end

endmodule

// File: rtl/spi_byte_master.sv
module spi_byte_master
  import spi_byte_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_msb_first,
  input  logic              cfg_cpha,
  input  logic              cfg_cpol,
  input  logic              cfg_cs_pulse,
  input  logic              cfg_cs_active_high,
  input  logic              cfg_cs_force_en,
  input  logic              cfg_cs_force_val,
  input  logic [DIV_W-1:0]  cfg_half_div,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              busy,
  output logic              sck,
  output logic              mosi,
  input  logic              miso,
  output logic              cs
);

  localparam int EDGES = 2 * DATA_W;
  localparam int EC_W  = $clog2(EDGES + 1);
  localparam logic [EC_W-1:0] LAST_EC = EC_W'(EDGES - 1);

  eng_state_t        state_q;
  frame_cfg_t        cfg_q;
  logic [DIV_W-1:0]  div_q;
  logic [EC_W-1:0]   edge_q;
  logic [EC_W-1:0]   edge_nxt;
  logic              gap_q;
  logic              sck_q;
  logic              rx_valid_q;
  logic [DATA_W-1:0] rx_data_q;

  logic              tick;
  logic              run;
  logic              abort;
  logic              edge_tick;
  logic              last_edge;
  logic              chain;
  logic              sample_now;
  logic              shift_now;
  logic              load;
  logic              mosi_bit;
  logic [DATA_W-1:0] rx_capt;
  logic              cs_on;
  logic              cs_high_eff;

  assign abort     = (state_q != ST_IDLE) &&
                     ((cfg_cpol != cfg_q.cpol) || (cfg_cpha != cfg_q.cpha));
  assign run       = (state_q != ST_IDLE) && !abort;
  assign edge_nxt  = edge_q + 1'b1;
  assign edge_tick = (state_q == ST_SHIFT) && tick;
  assign last_edge = edge_tick && (edge_q == LAST_EC);
  assign chain     = last_edge && tx_valid;
  assign load      = ((state_q == ST_IDLE) && tx_valid) || chain;

  // odd edge numbers sample when phase is 0, even ones when phase is 1
  assign sample_now = edge_tick && (edge_nxt[0] ^ cfg_q.cpha);
  assign shift_now  = edge_tick && !(edge_nxt[0] ^ cfg_q.cpha) &&
                      (edge_q != '0) && !last_edge;

  spi_half_timer #(.DIV_W(DIV_W)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run),
    .limit (div_q),
    .tick  (tick)
  );

  spi_shift_unit #(.DATA_W(DATA_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .msb_first (cfg_q.msb_first),
    .load      (load),
    .load_data (tx_data),
    .shift_tx  (shift_now),
    .sample    (sample_now),
    .miso      (miso),
    .mosi_bit  (mosi_bit),
    .rx_capt   (rx_capt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      cfg_q      <= '{msb_first: 1'b0, cpha: 1'b0, cpol: 1'b0, cs_pulse: 1'b1, cs_high: 1'b0};
      div_q      <= '0;
      edge_q     <= '0;
      gap_q      <= 1'b0;
      sck_q      <= 1'b0;
      rx_valid_q <= 1'b0;
      rx_data_q  <= '0;
    end else begin
      rx_valid_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (tx_valid) begin
            state_q <= ST_SHIFT;
            cfg_q   <= '{msb_first: cfg_msb_first, cpha: cfg_cpha, cpol: cfg_cpol,
                         cs_pulse: cfg_cs_pulse, cs_high: cfg_cs_active_high};
            div_q   <= cfg_half_div;
            edge_q  <= '0;
            sck_q   <= cfg_cpol;
          end
        end
        ST_SHIFT: begin
          if (abort) begin
            state_q <= ST_IDLE;
          end else if (edge_tick) begin
            sck_q  <= ~sck_q;
            edge_q <= edge_nxt;
            if (last_edge) begin
              rx_valid_q <= 1'b1;
              rx_data_q  <= rx_capt;
              if (!tx_valid) begin
                state_q <= ST_IDLE;
              end else if (cfg_q.cs_pulse) begin
                state_q <= ST_GAP;
                gap_q   <= 1'b0;
              end else begin
                edge_q <= '0;
              end
            end
          end
        end
        ST_GAP: begin
          if (abort) begin
            state_q <= ST_IDLE;
          end else if (tick) begin
            if (gap_q) begin
              state_q <= ST_SHIFT;
              edge_q  <= '0;
            end else begin
              gap_q <= 1'b1;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cs_on       = (state_q == ST_SHIFT);
  assign cs_high_eff = (state_q == ST_IDLE) ? cfg_cs_active_high : cfg_q.cs_high;

  assign busy     = (state_q != ST_IDLE);
  assign tx_ready = (state_q == ST_IDLE) || (last_edge && !abort);
  assign rx_valid = rx_valid_q;
  assign rx_data  = rx_data_q;
  assign sck      = (state_q == ST_IDLE) ? cfg_cpol : sck_q;
  assign mosi     = (state_q == ST_IDLE) ? 1'b0 : mosi_bit;
  assign cs       = cfg_cs_force_en ? cfg_cs_force_val :
                    (cs_on ? cs_high_eff : ~cs_high_eff);

endmodule

// File: rtl/spi_byte_master_chk.sv
module spi_byte_master_chk #(
  parameter int DIV_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             rx_valid,
  input logic             sck,
  input logic             cfg_cpol,
  input logic             cfg_cpha,
  input logic             cpol_q,
  input logic             cpha_q,
  input logic             sck_q,
  input logic [DIV_W-1:0] div_q,
  input logic             tick
);

  logic mode_moved;
  assign mode_moved = busy && ((cfg_cpol != cpol_q) || (cfg_cpha != cpha_q));

  // R10: receive strobe never lasts two cycles
  a_r10_rx_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  // R8: a clock-shape change while busy drops to idle with no strobe
  a_r8_abort_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
    mode_moved |=> (!busy && !rx_valid));

  // R3: a completed final byte leaves the serial clock at its resting level
  a_r3_sck_home: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !busy) |-> (sck_q == cpol_q));

  // R9: divider stays frozen through a run of busy cycles
  a_r9_div_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(div_q));

  // R4: the serial clock only moves on a half-period tick
  a_r4_sck_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tick && !mode_moved) |=> $stable(sck));

endmodule

bind spi_byte_master spi_byte_master_chk #(.DIV_W(DIV_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .busy     (busy),
  .rx_valid (rx_valid),
  .sck      (sck),
  .cfg_cpol (cfg_cpol),
  .cfg_cpha (cfg_cpha),
  .cpol_q   (cfg_q.cpol),
  .cpha_q   (cfg_q.cpha),
  .sck_q    (sck_q),
  .div_q    (div_q),
  .tick     (tick)
);

// File: tb/spi_byte_master_tb.sv
`timescale 1ns/1ps
module spi_byte_master_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_msb_first = 1'b0;
  logic       cfg_cpha = 1'b0;
  logic       cfg_cpol = 1'b0;
  logic       cfg_cs_pulse = 1'b1;
  logic       cfg_cs_active_high = 1'b0;
  logic       cfg_cs_force_en = 1'b0;
  logic       cfg_cs_force_val = 1'b0;
  logic [7:0] cfg_half_div = 8'd1;
  logic [7:0] tx_data = 8'h00;
  logic       tx_valid = 1'b0;
  logic       tx_ready;
  logic [7:0] rx_data;
  logic       rx_valid;
  logic       busy;
  logic       sck;
  logic       mosi;
  logic       miso;
  logic       cs;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  spi_byte_master u_dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_msb_first(cfg_msb_first), .cfg_cpha(cfg_cpha), .cfg_cpol(cfg_cpol),
    .cfg_cs_pulse(cfg_cs_pulse), .cfg_cs_active_high(cfg_cs_active_high),
    .cfg_cs_force_en(cfg_cs_force_en), .cfg_cs_force_val(cfg_cs_force_val),
    .cfg_half_div(cfg_half_div),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .rx_data(rx_data), .rx_valid(rx_valid), .busy(busy),
    .sck(sck), .mosi(mosi), .miso(miso), .cs(cs)
  );

  // pseudo-random slave data, changes just after each rising edge
  logic [15:0] lfsr = 16'hACE1;
  always @(posedge clk) begin
    #1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  end
  assign miso = lfsr[0];

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference: phase 0 idle, 1 shifting, 2 gap
  int         m_phase = 0;
  int         m_cnt = 0;
  int         m_edges = 0;
  int         m_gap = 0;
  int         m_sck = 0;
  int         m_bit = 0;
  int         m_rxi = 0;
  logic [7:0] m_byte = '0;
  logic [7:0] m_rxb = '0;
  logic [7:0] m_rxd = '0;
  int         m_rxv = 0;
  int         q_msb = 0, q_cpha = 0, q_cpol = 0, q_pulse = 1, q_high = 0, q_div = 0;

  function automatic bit m_abort();
    return (m_phase != 0) && ((int'(cfg_cpol) != q_cpol) || (int'(cfg_cpha) != q_cpha));
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_phase = 0; m_cnt = 0; m_edges = 0; m_gap = 0; m_sck = 0; m_rxv = 0;
      m_bit = 0; m_rxi = 0; m_rxd = '0;
      q_msb = 0; q_cpha = 0; q_cpol = 0; q_pulse = 1; q_high = 0; q_div = 0;
    end else begin
      m_rxv = 0;
      if (m_phase == 0) begin
        m_cnt = 0;
        if (tx_valid) begin
          q_msb = cfg_msb_first; q_cpha = cfg_cpha; q_cpol = cfg_cpol;
          q_pulse = cfg_cs_pulse; q_high = cfg_cs_active_high; q_div = cfg_half_div;
          m_phase = 1; m_edges = 0; m_sck = cfg_cpol;
          m_byte = tx_data; m_bit = 0; m_rxi = 0;
        end
      end else if (m_abort()) begin
        m_phase = 0; m_cnt = 0;
      end else begin
        bit tk;
        tk = (m_cnt == q_div);
        m_cnt = tk ? 0 : m_cnt + 1;
        if (tk && m_phase == 2) begin
          if (m_gap == 1) begin m_phase = 1; m_edges = 0; end
          else m_gap = 1;
        end else if (tk && m_phase == 1) begin
          int k;
          bit smp;
          k = m_edges + 1;
          m_sck = 1 - m_sck;
          smp = ((k % 2) == 1) ? (q_cpha == 0) : (q_cpha == 1);
          if (smp) begin
            m_rxb[q_msb ? 7 - m_rxi : m_rxi] = miso;
            m_rxi++;
          end else if (k != 1 && k != 16) begin
            m_bit++;
          end
          m_edges = k;
          if (k == 16) begin
            m_rxv = 1; m_rxd = m_rxb; m_rxi = 0;
            if (tx_valid) begin
              m_byte = tx_data; m_bit = 0;
              if (q_pulse != 0) begin m_phase = 2; m_gap = 0; end
              else m_edges = 0;
            end else begin
              m_phase = 0;
            end
          end
        end
      end
    end
  end

  // compare away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      int e_sck, e_mosi, e_cs, e_ready, e_hi;
      e_sck   = (m_phase == 0) ? int'(cfg_cpol) : m_sck;
      e_mosi  = (m_phase == 0) ? 0 : int'(q_msb ? m_byte[7 - m_bit] : m_byte[m_bit]);
      e_hi    = (m_phase == 0) ? int'(cfg_cs_active_high) : q_high;
      e_cs    = cfg_cs_force_en ? int'(cfg_cs_force_val) : ((m_phase == 1) ? e_hi : 1 - e_hi);
      e_ready = (m_phase == 0) ||
                ((m_phase == 1) && (m_cnt == q_div) && (m_edges == 15) && !m_abort());
      check(int'(sck) == e_sck, "R2 R3 R4 sck", sck, e_sck);
      check(int'(mosi) == e_mosi, "R1 R2 mosi", mosi, e_mosi);
      check(int'(cs) == e_cs, "R5 R6 R7 cs", cs, e_cs);
      check(int'(busy) == int'(m_phase != 0), "R10 busy", busy, m_phase != 0);
      check(int'(tx_ready) == e_ready, "R10 tx_ready", tx_ready, e_ready);
      check(int'(rx_valid) == m_rxv, "R8 R10 rx_valid", rx_valid, m_rxv);
      if (m_rxv == 1) check(rx_data == m_rxd, "R1 R2 R9 rx_data", rx_data, m_rxd);
    end
  end

  task automatic send(input logic [7:0] d);
    tx_data  = d;
    tx_valid = 1'b1;
    do @(negedge clk); while (!tx_ready);
    @(posedge clk); #1;
    tx_valid = 1'b0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (busy);
    repeat (3) @(posedge clk);
    #1;
  endtask

  task automatic set_mode(input bit msb, input bit pha, input bit pol, input bit pulse,
                          input bit high, input logic [7:0] dv);
    cfg_msb_first = msb; cfg_cpha = pha; cfg_cpol = pol;
    cfg_cs_pulse = pulse; cfg_cs_active_high = high; cfg_half_div = dv;
    @(posedge clk); #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    done = 1'b1;
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    #1;
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    check(busy == 1'b0, "R11 busy after reset", busy, 0);
    check(tx_ready == 1'b1, "R11 tx_ready after reset", tx_ready, 1);
    check(rx_valid == 1'b0, "R11 rx_valid after reset", rx_valid, 0);
    check(cs == 1'b1, "R11 cs idle after reset", cs, 1);
    check(sck == 1'b0, "R11 sck idle after reset", sck, 0);
    @(posedge clk); #1;

    // mode 0, LSB first, release between chained bytes (R6 pulse)
    set_mode(0, 0, 0, 1, 0, 8'd1);
    fork send(8'hA5); join
    send(8'h3C);
    wait_idle();

    // phase 1, MSB first, chained without release (R6 no gap)
    set_mode(1, 1, 0, 0, 0, 8'd2);
    send(8'h96); send(8'h0F); send(8'hE1);
    wait_idle();

    // polarity 1, phase 0, active-high select (R3 R5)
    set_mode(1, 0, 1, 1, 1, 8'd0);
    send(8'h5A); send(8'hC3);
    wait_idle();

    // polarity 1, phase 1, LSB first
    set_mode(0, 1, 1, 0, 0, 8'd3);
    send(8'h81);
    wait_idle();

    // R9 frozen settings: change them mid-byte
    set_mode(1, 0, 0, 1, 0, 8'd2);
    send(8'h6B);
    repeat (9) @(posedge clk);
    #1;
    cfg_msb_first = 1'b0; cfg_cs_active_high = 1'b1; cfg_cs_pulse = 1'b0; cfg_half_div = 8'd0;
    wait_idle();

    // R8 abort on phase change mid-byte
    set_mode(1, 0, 0, 1, 0, 8'd2);
    send(8'hF0);
    repeat (12) @(posedge clk);
    #1;
    cfg_cpha = 1'b1;
    wait_idle();
    send(8'h24);
    wait_idle();

    // R8 abort on polarity change mid-byte
    send(8'h99);
    repeat (7) @(posedge clk);
    #1;
    cfg_cpol = 1'b1;
    wait_idle();

    // R7 forced select during and after a transfer
    set_mode(0, 0, 0, 1, 0, 8'd1);
    cfg_cs_force_en = 1'b1; cfg_cs_force_val = 1'b1;
    send(8'h7E);
    repeat (10) @(posedge clk);
    #1;
    cfg_cs_force_val = 1'b0;
    wait_idle();
    @(negedge clk);
    check(cs == 1'b0, "R7 forced low while idle", cs, 0);
    @(posedge clk); #1;
    cfg_cs_force_en = 1'b0;
    wait_idle();

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule